// File: doc/BRIEF.md
# Oversampled Serial Receiver with Tagged Line Status

This block turns asynchronous serial frames on one input line into characters. An enable tick at sixteen times the bit rate paces the receiver. The receiver finds a start bit, checks it at mid-bit, and then samples the data bits, an optional parity bit and the stop bit, each at the middle of its bit time. The four format inputs set the word length, whether a parity bit is present and how it is checked.

Each finished character goes into a 16-entry receive queue. Three error tags travel with it: parity, framing and break. The status outputs report the tags of a character only when that character becomes the oldest entry in the queue. The status outputs also give data-ready, a sticky overrun flag and a cumulative "some queued character is bad" flag. A one-cycle pop strobe removes the oldest character. Its data is shown on the read port before the pop. A one-cycle status-read strobe clears the sticky flags.

After a bad stop bit, the receiver takes the low level it sampled as the start of the next frame. After a break, the receiver waits until the line returns high. Bit-rate generation and any bus or interrupt logic sit outside this block.

Top module: `serial_rx_status`

## Requirements
- R1: Word length follows the 2-bit code (00 gives 5 bits, 01 gives 6, 10 gives 7, 11 gives 8). Bits arrive LSB first and are sampled at mid-bit. The character sits in the low bits of the read data, and unused upper bits read as 0.
- R2: When parity is enabled, one parity bit follows the data and is checked against the 2-bit mode: 00 odd (data plus parity has an odd number of ones), 01 even, 10 bit must be 1, 11 bit must be 0. A mismatch tags the character with a parity error. With parity disabled, no parity bit is expected and no parity tag is ever set.
- R3: A finished character that meets a full queue (16 entries) sets the overrun flag in the next cycle. The fill level stays at 16, the queued characters are kept in order, and the new character is dropped.
- R4: A stop bit sampled low tags the character with a framing error. The receiver then treats that low sample as the start bit of the next frame, so data bits that follow at once, with no separate start bit, are received as a new character.
- R5: If the start, data, parity and stop samples of a frame are all low, exactly one character with value 0x00 is queued, carrying only the break tag. No further character is received until the line has been seen high.
- R6: The parity, framing and break flags are set from the tags of the character that becomes the oldest queue entry. An errored character queued behind a clean one raises no flag until the clean one is popped.
- R7: The cumulative error flag is set when an errored character becomes the oldest entry. A status read clears it only if no queued character still carries a tag.
- R8: A status read clears the overrun, parity, framing and break flags.
- R9: Data-ready is high exactly when the fill level is non-zero. The fill level counts queued characters from 0 to 16, and a pop of the last character drops data-ready.
- R10: A low pulse that has gone high again by the mid-bit check of the start bit is ignored and queues nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| serIn | input | 1 | Serial line, idle high |
| sampleTick | input | 1 | One-cycle enable at 16x the bit rate |
| wordLen | input | 2 | Word length code (R1) |
| parityOn | input | 1 | Parity bit present and checked |
| parityMode | input | 2 | Parity mode code (R2) |
| popReq | input | 1 | Remove the oldest queued character |
| popData | output | 8 | Oldest queued character |
| statusRead | input | 1 | Clears the sticky status flags |
| dataReady | output | 1 | Queue not empty |
| overrunFlag | output | 1 | Sticky overrun |
| parityFlag | output | 1 | Sticky parity error of an oldest entry |
| framingFlag | output | 1 | Sticky framing error of an oldest entry |
| breakFlag | output | 1 | Sticky break of an oldest entry |
| queueErrFlag | output | 1 | Cumulative queued-error flag |
| fillLevel | output | 5 | Number of queued characters |

## Verification
The bench targets these cases:
- A bad character queued behind a good one. A design that reported tags at enqueue time would raise the parity flag too early.
- A status read while a bad character is still queued. A design that cleared the cumulative error flag without looking at the queue would drop it.
- A stop bit that is low and is followed at once by data bits. A receiver that waited for a fresh falling edge would lose or shift that second character.
- An all-low break. A receiver that did not wait for the line to go high would queue a stream of zero characters.
- A seventeenth character into a full queue. A design that overwrote entries or moved the pointers would show the wrong data on the following pops.

Random frames of every width and parity mode, some with corrupted parity, check the parity equations against a bench model.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam logic [1:0] PAR_ODD  = 2'b00;
  localparam logic [1:0] PAR_EVEN = 2'b01;
  localparam logic [1:0] PAR_ONE  = 2'b10;
  localparam logic [1:0] PAR_ZERO = 2'b11;

  typedef struct packed {
    logic [7:0] data;
    logic       parErr;
    logic       frmErr;
    logic       brk;
  } rxs_entry_t;

  typedef struct packed {
    logic       push;
    rxs_entry_t entry;
  } rxs_strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_BRK
  } rxs_state_e;
endpackage

// File: rtl/rxs_ctrl.sv
module rxs_ctrl
  import rxs_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        serIn,
  input  logic        sampleTick,
  input  logic [1:0]  wordLen,
  input  logic        parityOn,
  input  logic [1:0]  parityMode,
  output rxs_strobe_t strb
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  logic rxMeta, rxS;
  rxs_state_e state;
  logic [CW-1:0] tickCnt;
  logic [2:0] bitIdx;
  logic [7:0] shiftData;
  logic zeroSoFar;
  logic parBit;
  logic expPar;
  logic [2:0] lastBit;

  assign lastBit = 3'(wordLen) + 3'd4;

  always_comb begin
    unique case (parityMode)
      PAR_ODD:  expPar = ~^shiftData;
      PAR_EVEN: expPar = ^shiftData;
      PAR_ONE:  expPar = 1'b1;
      default:  expPar = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta <= 1'b1;
      rxS    <= 1'b1;
    end else begin
      rxMeta <= serIn;
      rxS    <= rxMeta;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      tickCnt   <= '0;
      bitIdx    <= '0;
      shiftData <= '0;
      zeroSoFar <= 1'b0;
      parBit    <= 1'b0;
      strb      <= '0;
    end else begin
      strb.push <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (sampleTick && !rxS) begin
            state   <= ST_START;
            tickCnt <= '0;
          end
        end
        ST_START: begin
          if (sampleTick) begin
            if (tickCnt == MID) begin
              tickCnt <= '0;
              if (rxS) begin
                state <= ST_IDLE;
              end else begin
                state     <= ST_DATA;
                bitIdx    <= '0;
                shiftData <= '0;
                zeroSoFar <= 1'b1;
              end
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (sampleTick) begin
            if (tickCnt == LAST) begin
              tickCnt           <= '0;
              shiftData[bitIdx] <= rxS;
              zeroSoFar         <= zeroSoFar & ~rxS;
              if (bitIdx == lastBit) begin
                state <= parityOn ? ST_PAR : ST_STOP;
              end else begin
                bitIdx <= bitIdx + 1'b1;
              end
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
        end
        ST_PAR: begin
          if (sampleTick) begin
            if (tickCnt == LAST) begin
              tickCnt   <= '0;
              parBit    <= rxS;
              zeroSoFar <= zeroSoFar & ~rxS;
              state     <= ST_STOP;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
        end
        ST_STOP: begin
          if (sampleTick) begin
            if (tickCnt == LAST) begin
              tickCnt         <= '0;
              strb.push       <= 1'b1;
              strb.entry.data <= shiftData;
              if (zeroSoFar && !rxS) begin
                strb.entry.parErr <= 1'b0;
                strb.entry.frmErr <= 1'b0;
                strb.entry.brk    <= 1'b1;
                state             <= ST_BRK;
              end else begin
                strb.entry.parErr <= parityOn && (parBit != expPar);
                strb.entry.frmErr <= ~rxS;
                strb.entry.brk    <= 1'b0;
                if (!rxS) begin
                  state     <= ST_DATA;
                  bitIdx    <= '0;
                  shiftData <= '0;
                  zeroSoFar <= 1'b1;
                end else begin
                  state <= ST_IDLE;
                end
              end
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
        end
        ST_BRK: begin
          if (rxS) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5: a break character always carries value zero and no other tag
  p_break_clean_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.push && strb.entry.brk) |-> (strb.entry.data == 8'h00 && !strb.entry.frmErr && !strb.entry.parErr));

  // R5: each frame yields a single push pulse
  p_push_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |=> !strb.push);
endmodule

// File: rtl/rxs_fifo.sv
module rxs_fifo
  import rxs_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  rxs_entry_t                 wrEntry,
  input  logic                       rdEn,
  output rxs_entry_t                 head,
  output rxs_entry_t                 second,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  rxs_entry_t mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr, rdPtrNext;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign rdPtrNext = bump(rdPtr);
  assign head   = mem[rdPtr];
  assign second = mem[rdPtrNext];

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrPtr] <= wrEntry;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (wrEn) wrPtr <= bump(wrPtr);
      if (rdEn) rdPtr <= rdPtrNext;
      count <= count + CNT_W'(wrEn) - CNT_W'(rdEn);
    end
  end

  // R3: the queue never holds more than its depth
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));
endmodule

// File: rtl/rxs_data.sv
module rxs_data
  import rxs_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  rxs_strobe_t                strb,
  input  logic                       popReq,
  input  logic                       statusRead,
  output logic [7:0]                 popData,
  output logic                       dataReady,
  output logic                       overrunFlag,
  output logic                       parityFlag,
  output logic                       framingFlag,
  output logic                       breakFlag,
  output logic                       queueErrFlag,
  output logic [$clog2(DEPTH+1)-1:0] fillLevel
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] count, errCnt, errCntNext;
  logic full, wrEn, rdEn, headLoad;
  rxs_entry_t head, second, newHead;

  function automatic logic anyTag(input rxs_entry_t e);
    return e.parErr | e.frmErr | e.brk;
  endfunction

  assign full = (count == CNT_W'(DEPTH));
  assign wrEn = strb.push && !full;
  assign rdEn = popReq && (count != '0);

  rxs_fifo #(.DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrEntry(strb.entry),
    .rdEn(rdEn), .head(head), .second(second), .count(count)
  );

  always_comb begin
    headLoad = 1'b0;
    newHead  = strb.entry;
    if (wrEn && (count == '0 || (rdEn && count == CNT_W'(1)))) begin
      headLoad = 1'b1;
    end else if (rdEn && count > CNT_W'(1)) begin
      headLoad = 1'b1;
      newHead  = second;
    end
  end

  assign errCntNext = errCnt + CNT_W'(wrEn && anyTag(strb.entry))
                             - CNT_W'(rdEn && anyTag(head));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errCnt       <= '0;
      overrunFlag  <= 1'b0;
      parityFlag   <= 1'b0;
      framingFlag  <= 1'b0;
      breakFlag    <= 1'b0;
      queueErrFlag <= 1'b0;
    end else begin
      errCnt       <= errCntNext;
      overrunFlag  <= (overrunFlag && !statusRead) | (strb.push && full);
      parityFlag   <= (parityFlag  && !statusRead) | (headLoad && newHead.parErr);
      framingFlag  <= (framingFlag && !statusRead) | (headLoad && newHead.frmErr);
      breakFlag    <= (breakFlag   && !statusRead) | (headLoad && newHead.brk);
      queueErrFlag <= (queueErrFlag && !(statusRead && errCntNext == '0))
                    | (headLoad && anyTag(newHead));
    end
  end

  assign popData   = head.data;
  assign dataReady = (count != '0);
  assign fillLevel = count;

  // R3: a character arriving at a full queue raises overrun
  p_overrun_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.push && full) |=> overrunFlag);

  // R3: the dropped character leaves the fill level at depth
  p_overrun_keep_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.push && full && !popReq) |=> (fillLevel == CNT_W'(DEPTH)));

  // R8: a status read with no new overrun leaves the flag clear
  p_read_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && !(strb.push && full)) |=> !overrunFlag);

  // R9: popping the only character drops data-ready
  p_ready_drop_r9: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && fillLevel == CNT_W'(1) && !strb.push) |=> !dataReady);
endmodule

// File: rtl/serial_rx_status.sv
module serial_rx_status
  import rxs_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int OVS   = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             serIn,
  input  logic             sampleTick,
  input  logic [1:0]       wordLen,
  input  logic             parityOn,
  input  logic [1:0]       parityMode,
  input  logic             popReq,
  output logic [7:0]       popData,
  input  logic             statusRead,
  output logic             dataReady,
  output logic             overrunFlag,
  output logic             parityFlag,
  output logic             framingFlag,
  output logic             breakFlag,
  output logic             queueErrFlag,
  output logic [CNT_W-1:0] fillLevel
);
  rxs_strobe_t strb;

  rxs_ctrl #(.OVS(OVS)) ctrl_i (
    .clk(clk), .rstN(rstN), .serIn(serIn), .sampleTick(sampleTick),
    .wordLen(wordLen), .parityOn(parityOn), .parityMode(parityMode),
    .strb(strb)
  );

  rxs_data #(.DEPTH(DEPTH)) data_i (
    .clk(clk), .rstN(rstN), .strb(strb), .popReq(popReq),
    .statusRead(statusRead), .popData(popData), .dataReady(dataReady),
    .overrunFlag(overrunFlag), .parityFlag(parityFlag),
    .framingFlag(framingFlag), .breakFlag(breakFlag),
    .queueErrFlag(queueErrFlag), .fillLevel(fillLevel)
  );
endmodule

// File: tb/serial_rx_status_tb.sv
module serial_rx_status_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serIn = 1'b1;
  logic sampleTick = 1'b0;
  logic [1:0] wordLen = 2'b11;
  logic parityOn = 1'b0;
  logic [1:0] parityMode = 2'b00;
  logic popReq = 1'b0;
  logic statusRead = 1'b0;
  logic [7:0] popData;
  logic dataReady, overrunFlag, parityFlag, framingFlag, breakFlag, queueErrFlag;
  logic [4:0] fillLevel;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [1:0] tickDiv = '0;

  // model: {data[7:0], pe, fe, bi}
  logic [10:0] q[$];
  bit mOver, mPe, mFe, mBi, mErr;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    tickDiv    <= tickDiv + 1'b1;
    sampleTick <= (tickDiv == 2'd3);
  end

  serial_rx_status dut_i (
    .clk(clk), .rstN(rstN), .serIn(serIn), .sampleTick(sampleTick),
    .wordLen(wordLen), .parityOn(parityOn), .parityMode(parityMode),
    .popReq(popReq), .popData(popData), .statusRead(statusRead),
    .dataReady(dataReady), .overrunFlag(overrunFlag), .parityFlag(parityFlag),
    .framingFlag(framingFlag), .breakFlag(breakFlag),
    .queueErrFlag(queueErrFlag), .fillLevel(fillLevel)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] maskFor(input logic [1:0] wl);
    return 8'hFF >> (3 - wl);
  endfunction

  function automatic logic parFor(input logic [7:0] d, input logic [1:0] mode);
    case (mode)
      2'b00: return ~^d;
      2'b01: return ^d;
      2'b10: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit anyErr(input logic [10:0] e);
    return |e[2:0];
  endfunction

  function automatic void headLoad(input logic [10:0] e);
    mPe  |= e[2];
    mFe  |= e[1];
    mBi  |= e[0];
    mErr |= anyErr(e);
  endfunction

  function automatic void modelPush(input logic [10:0] e);
    if (q.size() == 16) mOver = 1;
    else begin
      if (q.size() == 0) headLoad(e);
      q.push_back(e);
    end
  endfunction

  function automatic void modelPop();
    void'(q.pop_front());
    if (q.size() > 0) headLoad(q[0]);
  endfunction

  function automatic void modelRead();
    bit left = 0;
    foreach (q[i]) if (anyErr(q[i])) left = 1;
    mOver = 0; mPe = 0; mFe = 0; mBi = 0;
    if (!left) mErr = 0;
  endfunction

  task automatic checkAll(input string tag);
    chk({tag, " R9 fill"}, fillLevel, q.size());
    chk({tag, " R9 ready"}, dataReady, q.size() != 0);
    chk({tag, " R3/R8 overrun"}, overrunFlag, mOver);
    chk({tag, " R6 parity"}, parityFlag, mPe);
    chk({tag, " R6 framing"}, framingFlag, mFe);
    chk({tag, " R6 break"}, breakFlag, mBi);
    chk({tag, " R7 queueErr"}, queueErrFlag, mErr);
    if (q.size() != 0) chk({tag, " R1 data"}, popData, q[0][10:3]);
  endtask

  task automatic bitHold(input logic v);
    serIn = v;
    repeat (64) @(negedge clk);
  endtask

  task automatic sendBody(input logic [7:0] d, input bit flip, input logic stopV);
    logic [7:0] m = d & maskFor(wordLen);
    for (int i = 0; i <= 3 + int'(wordLen) + 1; i++) bitHold(m[i]);
    if (parityOn) bitHold(parFor(m, parityMode) ^ flip);
    bitHold(stopV);
  endtask

  task automatic sendFrame(input logic [7:0] d, input bit flip);
    bitHold(1'b0);
    sendBody(d, flip, 1'b1);
    bitHold(1'b1);
    bitHold(1'b1);
    modelPush({d & maskFor(wordLen), parityOn & flip, 2'b00});
  endtask

  task automatic doPop(input string tag);
    popReq = 1'b1;
    @(negedge clk);
    popReq = 1'b0;
    @(negedge clk);
    modelPop();
    checkAll(tag);
  endtask

  task automatic doRead(input string tag);
    statusRead = 1'b1;
    @(negedge clk);
    statusRead = 1'b0;
    @(negedge clk);
    modelRead();
    checkAll(tag);
  endtask

  task automatic drain(input string tag);
    while (q.size() != 0) doPop(tag);
    doRead(tag);
  endtask

  task automatic setCfg(input logic [1:0] wl, input logic pOn, input logic [1:0] pm);
    wordLen = wl; parityOn = pOn; parityMode = pm;
    @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    checkAll("reset R9");

    // R1: every word length
    for (int wl = 0; wl < 4; wl++) begin
      setCfg(2'(wl), 1'b0, 2'b00);
      sendFrame(8'hFF, 0);
      checkAll("R1 width ones");
      sendFrame(8'hA5, 0);
      checkAll("R1 width pattern");
      drain("R1 drain");
    end

    // R2: each parity mode, good and corrupted
    for (int pm = 0; pm < 4; pm++) begin
      setCfg(2'b11, 1'b1, 2'(pm));
      sendFrame(8'h6B, 0);
      checkAll("R2 parity good");
      doPop("R2 pop good");
      sendFrame(8'h6B, 1);
      checkAll("R2 parity bad");
      drain("R2 drain");
    end

    // R6: tag reported only when the bad character becomes the oldest
    setCfg(2'b11, 1'b1, 2'b01);
    sendFrame(8'h11, 0);
    sendFrame(8'h22, 1);
    chk("R6 flag waits behind clean char", parityFlag, 0);
    checkAll("R6 queued");
    doPop("R6 head reached");
    chk("R6 flag after head reached", parityFlag, 1);
    drain("R6 drain");

    // R7: cumulative flag survives a read while a bad char is queued
    sendFrame(8'h33, 1);
    sendFrame(8'h44, 1);
    doRead("R7 read with errs queued");
    chk("R7 flag kept", queueErrFlag, 1);
    doPop("R7 pop1");
    doPop("R7 pop2");
    doRead("R7 read after empty");
    chk("R7 flag cleared", queueErrFlag, 0);

    // R4: low stop bit, then data immediately
    setCfg(2'b11, 1'b0, 2'b00);
    bitHold(1'b0);
    sendBody(8'h3C, 0, 1'b0);
    sendBody(8'h5A, 0, 1'b1);
    bitHold(1'b1);
    bitHold(1'b1);
    modelPush({8'h3C, 3'b010});
    modelPush({8'h5A, 3'b000});
    checkAll("R4 framing resync");
    chk("R4 two chars", fillLevel, 2);
    drain("R4 drain");

    // R5: break holds, then a normal frame
    setCfg(2'b11, 1'b1, 2'b00);
    serIn = 1'b0;
    repeat (14 * 64) @(negedge clk);
    modelPush({8'h00, 3'b001});
    checkAll("R5 break while low");
    chk("R5 single break char", fillLevel, 1);
    bitHold(1'b1);
    bitHold(1'b1);
    sendFrame(8'h81, 0);
    checkAll("R5 after break");
    drain("R5 drain");

    // R10: short low glitch
    serIn = 1'b0;
    repeat (16) @(negedge clk);
    bitHold(1'b1);
    bitHold(1'b1);
    checkAll("R10 glitch ignored");
    chk("R10 nothing queued", fillLevel, 0);

    // R3: overrun on a full queue
    setCfg(2'b11, 1'b0, 2'b00);
    for (int i = 0; i < 17; i++) sendFrame(8'(i * 7 + 1), 0);
    chk("R3 overrun set", overrunFlag, 1);
    chk("R3 fill at depth", fillLevel, 16);
    checkAll("R3 full");
    while (q.size() != 0) doPop("R3 content kept");
    doRead("R8 read clears overrun");
    chk("R8 overrun clear", overrunFlag, 0);

    // random frames
    for (int n = 0; n < 40; n++) begin
      setCfg(2'($urandom % 4), 1'($urandom % 2), 2'($urandom % 4));
      sendFrame(8'($urandom), ($urandom % 5) == 0);
      checkAll("R2 random");
      if (q.size() > 10 || ($urandom % 3) == 0) doPop("R1 random pop");
      if (($urandom % 4) == 0) doRead("R8 random read");
    end
    drain("final drain");

    summary();
  end
endmodule